// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block runs the write side of a serial flash memory: page program, page erase, sector erase and bulk erase. The SPI front-end passes it the received bytes one at a time, along with pulses that mark chip select falling and rising. On each rising pulse the front-end also reports whether the rise came during SCK low, right after a whole byte. When chip select rises on a correctly framed, permitted and write-enabled instruction, the sequencer commits the operation. It then holds a busy state for a set time and drives a byte-wide write port of the array.

The array is divided into 256-byte pages and two equal sectors. Programming can only clear bits, so each written byte is the old content ANDed with the new data. Erasing sets bytes to 0xFF. The status/protection block supplies the write-enable latch and the two block-protect bits. That block shows `busy` as both the busy bit and the write-enable bit while a cycle runs, and it clears its write-enable latch on the `wel_clr` pulse. Each operation has a cycle-count parameter that stands in for the analog duration, so simulation can use short counts.

Top module: `flash_pe_seq`

## Requirements
- R1: The first byte after a chip-select fall is the opcode. 0x02 means page program, 0x81 page erase, 0xD8 sector erase and 0xC7 bulk erase. Any other opcode is ignored until the next chip-select fall. Address bytes follow MSB first, three of them, and only the low ADDR_W bits are used.
- R2: An instruction is committed only if `wel_in` is high in the cycle `cs_rise` is pulsed. Otherwise the block returns to standby and neither the array nor `busy` changes.
- R3: A commit also needs `cs_aligned` high with `cs_rise`, and an exact byte count. Bulk erase takes the opcode only. Page and sector erase take the opcode plus three address bytes. Page program takes the opcode, three address bytes and at least one data byte.
- R4: Page program writes only the received byte positions, each as old data AND new data. Every other byte of the array is left unchanged.
- R5: During page program only the low 8 address bits increment, with no carry into the page number. If more than 256 data bytes arrive, later bytes replace earlier ones at the same position.
- R6: Page erase sets the addressed 256-byte page to 0xFF. Sector erase sets the addressed half of the array to 0xFF. Bulk erase sets the whole array to 0xFF. Bytes outside the target keep their content.
- R7: The protect bits `bp_in` select the protected region: 00 none, 01 the top quarter, 10 the top half, 11 everything. Program, page erase and sector erase whose target overlaps the protected region are ignored. Bulk erase runs only when `bp_in` is 00.
- R8: `busy` rises in the cycle after the commit edge. It stays high for the larger of two counts: the walk length or the operation's duration parameter. The walk length is 256 for program and page erase, 2^(ADDR_W-1) for sector erase and 2^ADDR_W for bulk erase.
- R9: While `busy` is high, every front-end input is ignored, including a complete, enabled instruction.
- R10: `wel_clr` is a single-cycle pulse, high exactly in the first cycle after `busy` falls.
- R11: The array is written only while `busy` is high. Each write is either 0xFF or clears bits of the old byte, never setting any.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_fall | input | 1 | Pulse: chip select fell, a new instruction starts |
| cs_rise | input | 1 | Pulse: chip select rose, the instruction ends |
| cs_aligned | input | 1 | With cs_rise: the rise came during SCK low, right after a whole byte |
| rx_vld | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte, MSB-first assembled |
| wel_in | input | 1 | Write-enable latch from the status block |
| bp_in | input | 2 | Block-protect level |
| busy | output | 1 | Program/erase cycle in progress |
| wel_clr | output | 1 | Pulse: cycle finished, clear write enable |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array address for read and write |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data at arr_addr, same cycle |

## Verification
The commit is sampled on the clock edge that sees `cs_rise`. `busy` is therefore expected at the first falling-edge sample after that pulse. The bench counts falling-edge samples with `busy` high and compares the count with the larger of the walk length and the duration parameter. At the first sample with `busy` low it expects `wel_clr` high, and at the sample after that it expects `wel_clr` low. Array contents are checked only after `busy` has fallen, since the last write lands on the edge that clears `busy`. For ignored instructions, the bench confirms that `busy` stays low for several samples and that the target bytes keep their earlier values.

// File: rtl/flash_pe_seq.sv
module flash_pe_seq #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32,
  parameter int PP_CYC = 900000,
  parameter int PE_CYC = 300000,
  parameter int SE_CYC = 30000000,
  parameter int BE_CYC = 50000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  input  logic              wel_in,
  input  logic [1:0]        bp_in,
  output logic              busy,
  output logic              wel_clr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  input  logic [7:0]        arr_rdata
);
  localparam int PAGE_W = 8;
  localparam int PAGE_B = 1 << PAGE_W;
  localparam logic [7:0] OP_PP = 8'h02, OP_PE = 8'h81, OP_SE = 8'hD8, OP_BE = 8'hC7;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_DROP, S_BUSY} st_t;

  st_t st;
  logic [7:0]        opc;
  logic [2:0]        bcnt;
  logic [ADDR_W-1:0] tgt;
  logic [PAGE_W-1:0] wptr;
  logic [7:0]        pbuf [PAGE_B];
  logic [PAGE_B-1:0] vmask;
  logic [ADDR_W-1:0] widx;
  logic              wdone;
  logic [CNT_W-1:0]  tcnt;

  logic              frame_ok, prot, go, fin, walk_last, buf_wr, rx_take;
  logic [ADDR_W-1:0] wmask;
  logic [CNT_W-1:0]  dur;

  wire is_pp    = (opc == OP_PP);
  wire top_half = tgt[ADDR_W-1];
  wire top_q    = &tgt[ADDR_W-1 -: 2];
  wire op_known = (rx_byte == OP_PP) || (rx_byte == OP_PE) ||
                  (rx_byte == OP_SE) || (rx_byte == OP_BE);

  always_comb begin
    frame_ok = 1'b0;
    prot     = 1'b1;
    wmask    = '1;
    dur      = CNT_W'(BE_CYC);
    case (opc)
      OP_PP, OP_PE: begin
        frame_ok = is_pp ? (bcnt == 3'd5) : (bcnt == 3'd4);
        prot     = (bp_in == 2'b11) || (bp_in == 2'b10 && top_half) || (bp_in == 2'b01 && top_q);
        wmask    = ADDR_W'(PAGE_B - 1);
        dur      = is_pp ? CNT_W'(PP_CYC) : CNT_W'(PE_CYC);
      end
      OP_SE: begin
        frame_ok = (bcnt == 3'd4);
        prot     = (bp_in == 2'b11) || (bp_in != 2'b00 && top_half);
        wmask    = {1'b0, {(ADDR_W-1){1'b1}}};
        dur      = CNT_W'(SE_CYC);
      end
      OP_BE: begin
        frame_ok = (bcnt == 3'd1);
        prot     = (bp_in != 2'b00);
      end
      default: ;
    endcase
  end

  assign busy      = (st == S_BUSY);
  assign walk_last = (widx == wmask);
  assign arr_addr  = (tgt & ~wmask) | widx;
  assign arr_we    = busy && !wdone && (!is_pp || vmask[widx[PAGE_W-1:0]]);
  assign arr_wdata = is_pp ? (arr_rdata & pbuf[widx[PAGE_W-1:0]]) : 8'hFF;
  assign fin       = busy && (wdone || walk_last) && (tcnt >= dur - CNT_W'(1));
  assign go        = cs_aligned && wel_in && frame_ok && !prot;
  assign rx_take   = (st == S_RX) && !cs_rise && !cs_fall && rx_vld;
  assign buf_wr    = rx_take && (bcnt >= 3'd4) && is_pp;

  always_ff @(posedge clk) begin
    if (buf_wr) pbuf[wptr] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      opc     <= '0;
      bcnt    <= '0;
      tgt     <= '0;
      wptr    <= '0;
      vmask   <= '0;
      widx    <= '0;
      wdone   <= 1'b0;
      tcnt    <= '0;
      wel_clr <= 1'b0;
    end else begin
      wel_clr <= 1'b0;
      case (st)
        S_IDLE, S_DROP: begin
          if (cs_fall) begin
            st    <= S_RX;
            bcnt  <= '0;
            vmask <= '0;
          end else if (cs_rise) begin
            st <= S_IDLE;
          end
        end
        S_RX: begin
          if (cs_rise) begin
            st    <= go ? S_BUSY : S_IDLE;
            widx  <= '0;
            wdone <= 1'b0;
            tcnt  <= '0;
          end else if (cs_fall) begin
            bcnt  <= '0;
            vmask <= '0;
          end else if (rx_vld) begin
            bcnt <= (bcnt == 3'd5) ? bcnt : bcnt + 3'd1;
            if (bcnt == 3'd0) begin
              opc <= rx_byte;
              if (!op_known) st <= S_DROP;
            end else if (bcnt < 3'd4) begin
              tgt <= {tgt[ADDR_W-PAGE_W-1:0], rx_byte};
              if (bcnt == 3'd3) wptr <= rx_byte;
            end else if (is_pp) begin
              vmask[wptr] <= 1'b1;
              wptr        <= wptr + 1'b1;
            end
          end
        end
        S_BUSY: begin
          tcnt <= tcnt + CNT_W'(1);
          if (!wdone) begin
            widx  <= widx + 1'b1;
            wdone <= walk_last;
          end
          if (fin) begin
            st      <= S_IDLE;
            wel_clr <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              cs_aligned,
  input logic              wel_in,
  input logic              busy,
  input logic              wel_clr,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [7:0]        arr_wdata,
  input logic [7:0]        arr_rdata
);
  assert_write_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  assert_no_bit_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_wdata == 8'hFF) || ((arr_wdata & ~arr_rdata) == 8'h00));

  assert_start_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && wel_in));

  assert_start_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_aligned));

  assert_clr_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wel_clr);

  assert_clr_only_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> !busy && $past(busy));

  assert_addr_stable_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !arr_we);

  logic unused_addr;
  assign unused_addr = ^arr_addr;
endmodule

bind flash_pe_seq flash_pe_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
  .wel_in(wel_in), .busy(busy), .wel_clr(wel_clr), .arr_we(arr_we),
  .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
);

// File: tb/flash_pe_seq_tb_top.sv
module flash_pe_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int PE_LEN = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_fall = 0, cs_rise = 0, cs_aligned = 0, rx_vld = 0, wel_in = 0;
  logic [7:0] rx_byte = 0;
  logic [1:0] bp_in = 0;
  logic busy, wel_clr, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata, arr_rdata;

  logic [7:0] mem [0:(1<<AW)-1];
  logic [7:0] tx [0:299];
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pe_seq #(.ADDR_W(AW), .CNT_W(16), .PP_CYC(50), .PE_CYC(PE_LEN),
                 .SE_CYC(10), .BE_CYC(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cs_aligned(cs_aligned), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .wel_in(wel_in), .bp_in(bp_in), .busy(busy), .wel_clr(wel_clr),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata));

  assign arr_rdata = mem[arr_addr];
  always_ff @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_cmd(input logic [7:0] op, input logic [23:0] a);
    tx[0] = op; tx[1] = a[23:16]; tx[2] = a[15:8]; tx[3] = a[7:0];
  endtask

  task automatic frame(input int n, input bit aligned);
    @(negedge clk) cs_fall = 1;
    @(negedge clk) cs_fall = 0;
    for (int i = 0; i < n; i++) begin
      rx_vld = 1; rx_byte = tx[i];
      @(negedge clk) rx_vld = 0;
      @(negedge clk);
    end
    cs_aligned = aligned; cs_rise = 1;
    @(negedge clk) cs_rise = 0; cs_aligned = 0;
  endtask

  task automatic wait_done(output int cyc, output int clr);
    cyc = 0; clr = 0;
    while (busy && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 20000) check("watchdog busy", 1, 0);
    if (wel_clr) clr++;
    @(negedge clk);
    if (wel_clr) clr++;
  endtask

  task automatic no_start(input string req);
    int hits = 0;
    for (int i = 0; i < 4; i++) begin
      if (busy) hits++;
      @(negedge clk);
    end
    check(req, hits, 0);
  endtask

  task automatic op_run(input int n, output int cyc, output int clr);
    frame(n, 1);
    wait_done(cyc, clr);
  endtask

  task automatic prog(input logic [23:0] a, input logic [7:0] d);
    int c, k;
    set_cmd(8'h02, a); tx[4] = d;
    op_run(5, c, k);
  endtask

  task automatic t_reset;
    check("R8 reset busy", busy, 0);
    check("R10 reset wel_clr", wel_clr, 0);
    check("R11 reset arr_we", arr_we, 0);
  endtask

  task automatic t_bulk;
    int c, k, mis = 0;
    wel_in = 1; bp_in = 0;
    tx[0] = 8'hC7;
    op_run(1, c, k);
    check("R8 bulk busy length", c, 1 << AW);
    check("R10 bulk wel_clr single pulse", k, 1);
    for (int i = 0; i < (1 << AW); i++) if (mem[i] !== 8'hFF) mis++;
    check("R6 bulk erase all FF", mis, 0);
  endtask

  task automatic t_program;
    int c, k;
    set_cmd(8'h02, 24'h000230); tx[4] = 8'hA5; tx[5] = 8'h3C; tx[6] = 8'hF0;
    op_run(7, c, k);
    check("R8 program busy length", c, 256);
    check("R4 byte 0", mem[12'h230], 8'hA5);
    check("R4 byte 1", mem[12'h231], 8'h3C);
    check("R4 byte 2", mem[12'h232], 8'hF0);
    check("R4 before untouched", mem[12'h22F], 8'hFF);
    check("R4 after untouched", mem[12'h233], 8'hFF);
    prog(24'h000230, 8'h0F);
    check("R4 old AND new", mem[12'h230], 8'h05);
    check("R4 second pass keeps neighbour", mem[12'h231], 8'h3C);
  endtask

  task automatic t_wrap;
    int c, k;
    set_cmd(8'h02, 24'h0003FE);
    tx[4] = 8'h11; tx[5] = 8'h22; tx[6] = 8'h33; tx[7] = 8'h44;
    op_run(8, c, k);
    check("R5 at FE", mem[12'h3FE], 8'h11);
    check("R5 at FF", mem[12'h3FF], 8'h22);
    check("R5 wrapped to 00", mem[12'h300], 8'h33);
    check("R5 wrapped to 01", mem[12'h301], 8'h44);
    check("R5 no carry into next page", mem[12'h400], 8'hFF);
    set_cmd(8'h02, 24'h000500);
    tx[4] = 8'h0F;
    for (int i = 1; i < 256; i++) tx[4+i] = 8'hEE;
    tx[260] = 8'hF0;
    op_run(261, c, k);
    check("R5 overflow byte replaces first", mem[12'h500], 8'hF0);
    check("R5 overflow keeps second", mem[12'h501], 8'hEE);
  endtask

  task automatic t_wel_off;
    wel_in = 0;
    set_cmd(8'h02, 24'h000600); tx[4] = 8'h00;
    frame(5, 1);
    no_start("R2 no busy without write enable");
    check("R2 array unchanged", mem[12'h600], 8'hFF);
    wel_in = 1;
  endtask

  task automatic t_align;
    set_cmd(8'h02, 24'h000610); tx[4] = 8'h00;
    frame(5, 0);
    no_start("R3 misaligned rise no busy");
    check("R3 misaligned program ignored", mem[12'h610], 8'hFF);
    set_cmd(8'h81, 24'h000200); tx[4] = 8'h00;
    frame(5, 1);
    no_start("R3 page erase extra byte");
    check("R3 page erase extra byte ignored", mem[12'h230], 8'h05);
    frame(3, 1);
    no_start("R3 page erase short address");
    tx[0] = 8'hC7; tx[1] = 8'h00;
    frame(2, 1);
    no_start("R3 bulk erase extra byte");
    check("R3 bulk erase extra byte ignored", mem[12'h230], 8'h05);
  endtask

  task automatic t_unknown;
    set_cmd(8'h03, 24'h000230); tx[4] = 8'h00;
    frame(5, 1);
    no_start("R1 unknown opcode no busy");
    check("R1 unknown opcode array unchanged", mem[12'h230], 8'h05);
  endtask

  task automatic t_page_erase;
    int c, k;
    set_cmd(8'h81, 24'h000231);
    op_run(4, c, k);
    check("R8 page erase busy length", c, PE_LEN);
    check("R10 page erase wel_clr", k, 1);
    check("R6 page erased", mem[12'h230], 8'hFF);
    check("R6 neighbour page kept", mem[12'h300], 8'h33);
  endtask

  task automatic t_busy_ignore;
    int c, k;
    set_cmd(8'h81, 24'h000300);
    frame(4, 1);
    check("R9 erase started", busy, 1);
    set_cmd(8'h02, 24'h000700); tx[4] = 8'h00;
    frame(5, 1);
    wait_done(c, k);
    no_start("R9 no second cycle");
    check("R9 instruction during busy ignored", mem[12'h700], 8'hFF);
    check("R6 busy page erased", mem[12'h3FE], 8'hFF);
  endtask

  task automatic t_sector;
    int c, k, mis = 0;
    prog(24'h000100, 8'h12);
    prog(24'h000900, 8'h34);
    set_cmd(8'hD8, 24'h000123);
    op_run(4, c, k);
    check("R8 sector busy length", c, 1 << (AW - 1));
    for (int i = 0; i < (1 << (AW - 1)); i++) if (mem[i] !== 8'hFF) mis++;
    check("R6 sector erased", mis, 0);
    check("R6 other sector kept", mem[12'h900], 8'h34);
  endtask

  task automatic t_protect;
    int c, k;
    bp_in = 2'b01;
    prog(24'h000C10, 8'h00);
    check("R7 quarter blocks top", mem[12'hC10], 8'hFF);
    prog(24'h000810, 8'h00);
    check("R7 quarter allows lower", mem[12'h810], 8'h00);
    set_cmd(8'hD8, 24'h000900);
    op_run(4, c, k);
    check("R7 quarter blocks sector erase", mem[12'h900], 8'h34);
    tx[0] = 8'hC7;
    op_run(1, c, k);
    check("R7 bulk needs zero bits", mem[12'h810], 8'h00);
    bp_in = 2'b10;
    prog(24'h000820, 8'h00);
    check("R7 half blocks upper", mem[12'h820], 8'hFF);
    prog(24'h000020, 8'h00);
    check("R7 half allows lower", mem[12'h020], 8'h00);
    bp_in = 2'b11;
    prog(24'h000010, 8'h00);
    check("R7 all blocked", mem[12'h010], 8'hFF);
    bp_in = 2'b00;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_bulk();
    t_program();
    t_wrap();
    t_wel_off();
    t_align();
    t_unknown();
    t_page_erase();
    t_busy_ignore();
    t_sector();
    t_protect();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule